// File: doc/BRIEF.md
# ROM Search Step Engine

This block carries out one step of a ROM search on a single-wire bus as one hardware operation. A `start` pulse launches it, with a requested branch direction. It then reads two bits from the bus through a lower single-bit transfer interface. The first is the address bit from the slaves and the second is that bit's complement. From these two bits and the requested direction it decides which branch to take, and it writes that direction bit back on the bus. It then reports a 3-bit result with a one-cycle `done` pulse.

The slot timing on the wire belongs to the transfer layer below. The engine only issues a slot request, marks it as a read or a write, and waits for that slot's completion strobe. Each wait is bounded by a cycle limit set by a parameter. Software or a search sequencer above keeps the 64-bit search state and checks the CRC. It calls this engine once per bit position.

Top module: `rom_search_step`

## Requirements
- R1: An accepted step issues slot requests in this order: a read for the address bit, a read for the complement bit, then a write of the chosen direction. `slotReq` is high for exactly one cycle per slot, and `slotIsRead` is 1 for the reads and 0 for the write.
- R2: When both read bits are 1 (no slave present), no write slot is issued and the step finishes with result 3'b011 and `error` low.
- R3: When both read bits are 0 (a conflict), the requested direction latched at start is written on `slotTxBit`. The result is 3'b100 for direction 1 and 3'b000 for direction 0.
- R4: When exactly one read bit is 1, the direction written is the address bit. The result is 3'b101 when the address bit is 1 and 3'b010 when the complement bit is 1.
- R5: The result layout is bit0 = address bit, bit1 = complement bit, bit2 = direction taken. Each slot completes on `slotDone`, and a `slotDone` arriving on the TIMEOUT_CYCLES-th cycle of waiting is still accepted.
- R6: If `slotDone` is not seen within TIMEOUT_CYCLES wait cycles of any slot, the step aborts. No further slot is issued, the result is 3'b011, and `error` is 1 in the same cycle as `done`.
- R7: A `start` while a step is in progress is ignored. The step in progress keeps its original requested direction and slot count.
- R8: `done` is a one-cycle pulse. `result` and `error` hold their values until the next accepted start, which clears them to 3'b000 and 0.
- R9: After reset no slot is requested, `done` and `error` are 0, and `result` is 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch one search step (ignored while busy) |
| reqDir | input | 1 | Requested direction for a conflict |
| slotReq | output | 1 | One-cycle request for a single-bit slot |
| slotIsRead | output | 1 | 1 = read slot, 0 = write slot |
| slotTxBit | output | 1 | Bit to send in a write slot |
| slotRxBit | input | 1 | Bit received, valid with slotDone on reads |
| slotDone | input | 1 | Completion strobe of the current slot |
| done | output | 1 | One-cycle completion pulse of the step |
| error | output | 1 | Step aborted on a slot timeout |
| result | output | 3 | {direction, complement bit, address bit} |

## Verification
The bench builds the engine with TIMEOUT_CYCLES = 8, so a timeout takes only a few cycles to reach. With that value the bench exercises the boundary where a completion on the eighth wait cycle is accepted and a missing one aborts. It covers aborts on the first read and on the write slot. It also varies completion latency per slot, and pulses start in the middle of a step with the opposite direction.

// File: rtl/rom_search_pkg.sv
package rom_search_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE_ID,
    ST_WAIT_ID,
    ST_ISSUE_CMP,
    ST_WAIT_CMP,
    ST_ISSUE_WR,
    ST_WAIT_WR
  } stepState_t;

  typedef struct packed {
    logic accept;   // start taken: latch direction, clear outputs
    logic capId;    // address bit arrived
    logic capCmp;   // complement bit arrived
    logic finish;   // step ends normally
    logic abort;    // slot timed out
  } stepStrb_t;

  localparam logic [2:0] RES_NO_SLAVE = 3'b011;

endpackage

// File: rtl/rom_search_ctl.sv
module rom_search_ctl
  import rom_search_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 4096
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      slotDone,
  input  logic      noSlave,
  output logic      slotReq,
  output logic      slotIsRead,
  output stepStrb_t strb
);

  localparam int TIMER_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [TIMER_W-1:0] TIMER_LAST = TIMER_W'(TIMEOUT_CYCLES - 1);

  stepState_t state, stateNext;
  logic [TIMER_W-1:0] timer;
  logic inWait, expired;

  assign inWait  = (state == ST_WAIT_ID) || (state == ST_WAIT_CMP) || (state == ST_WAIT_WR);
  assign expired = inWait && !slotDone && (timer == TIMER_LAST);

  assign slotReq    = (state == ST_ISSUE_ID) || (state == ST_ISSUE_CMP) || (state == ST_ISSUE_WR);
  assign slotIsRead = (state != ST_ISSUE_WR) && (state != ST_WAIT_WR);

  always_comb begin
    stateNext   = state;
    strb        = '0;
    strb.abort  = expired;
    unique case (state)
      ST_IDLE: if (start) begin
        strb.accept = 1'b1;
        stateNext   = ST_ISSUE_ID;
      end
      ST_ISSUE_ID:  stateNext = ST_WAIT_ID;
      ST_WAIT_ID: if (slotDone) begin
        strb.capId = 1'b1;
        stateNext  = ST_ISSUE_CMP;
      end
      ST_ISSUE_CMP: stateNext = ST_WAIT_CMP;
      ST_WAIT_CMP: if (slotDone) begin
        strb.capCmp = 1'b1;
        if (noSlave) begin
          strb.finish = 1'b1;
          stateNext   = ST_IDLE;
        end else begin
          stateNext = ST_ISSUE_WR;
        end
      end
      ST_ISSUE_WR:  stateNext = ST_WAIT_WR;
      ST_WAIT_WR: if (slotDone) begin
        strb.finish = 1'b1;
        stateNext   = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
    if (expired) stateNext = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      timer <= '0;
    end else begin
      state <= stateNext;
      if (!inWait || slotDone) timer <= '0;
      else if (!expired)       timer <= timer + 1'b1;
    end
  end

  // R1: each slot request lasts a single cycle
  p_one_cycle_req_r1: assert property (@(posedge clk) disable iff (!rstN)
    slotReq |=> !slotReq);

  // R5: the wait counter never passes the limit
  p_timer_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    timer <= TIMER_LAST);

  // R2: no write slot after an empty bus
  p_skip_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT_CMP && slotDone && noSlave) |=> (state == ST_IDLE && !slotReq));

  // R7: a busy engine never restarts
  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |=> (state != ST_ISSUE_ID));

endmodule

// File: rtl/rom_search_dp.sv
module rom_search_dp
  import rom_search_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  stepStrb_t strb,
  input  logic      reqDir,
  input  logic      slotRxBit,
  output logic      noSlave,
  output logic      slotTxBit,
  output logic      done,
  output logic      error,
  output logic [2:0] result
);

  logic idQ, cmpQ, dirQ, reqDirQ;
  logic dirPick;
  logic [2:0] resNext;

  // decision taken as the complement bit arrives
  assign noSlave = idQ & slotRxBit;
  assign dirPick = (idQ ^ slotRxBit) ? idQ : reqDirQ;
  assign resNext = strb.capCmp ? RES_NO_SLAVE : {dirQ, cmpQ, idQ};
  assign slotTxBit = dirQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idQ     <= 1'b0;
      cmpQ    <= 1'b0;
      dirQ    <= 1'b0;
      reqDirQ <= 1'b0;
      done    <= 1'b0;
      error   <= 1'b0;
      result  <= '0;
    end else begin
      done <= strb.finish | strb.abort;
      if (strb.accept) begin
        reqDirQ <= reqDir;
        result  <= '0;
        error   <= 1'b0;
      end
      if (strb.capId) idQ <= slotRxBit;
      if (strb.capCmp) begin
        cmpQ <= slotRxBit;
        dirQ <= dirPick;
      end
      if (strb.finish) result <= resNext;
      if (strb.abort) begin
        result <= RES_NO_SLAVE;
        error  <= 1'b1;
      end
    end
  end

  // R8: completion is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6: an abort is reported together with done
  p_error_with_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(error) |-> done);

  // R4: a lone responding bit forces the written direction
  p_forced_dir_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capCmp && (idQ != slotRxBit)) |=> (slotTxBit == $past(idQ)));

endmodule

// File: rtl/rom_search_step.sv
module rom_search_step
  import rom_search_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 4096
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       reqDir,
  output logic       slotReq,
  output logic       slotIsRead,
  output logic       slotTxBit,
  input  logic       slotRxBit,
  input  logic       slotDone,
  output logic       done,
  output logic       error,
  output logic [2:0] result
);

  stepStrb_t strb;
  logic noSlave;

  rom_search_ctl #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .slotDone   (slotDone),
    .noSlave    (noSlave),
    .slotReq    (slotReq),
    .slotIsRead (slotIsRead),
    .strb       (strb)
  );

  rom_search_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqDir    (reqDir),
    .slotRxBit (slotRxBit),
    .noSlave   (noSlave),
    .slotTxBit (slotTxBit),
    .done      (done),
    .error     (error),
    .result    (result)
  );

endmodule

// File: tb/tb_rom_search_step.sv
module tb_rom_search_step;

  localparam int LIM = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, reqDir = 1'b0, slotRxBit = 1'b0, slotDone = 1'b0;
  logic slotReq, slotIsRead, slotTxBit, done, error;
  logic [2:0] result;

  int nChecks = 0, nFails = 0;
  int stepReqs = 0;
  bit countOn = 1'b0;

  always #5 clk = ~clk;

  rom_search_step #(.TIMEOUT_CYCLES(LIM)) dut (
    .clk(clk), .rstN(rstN), .start(start), .reqDir(reqDir),
    .slotReq(slotReq), .slotIsRead(slotIsRead), .slotTxBit(slotTxBit),
    .slotRxBit(slotRxBit), .slotDone(slotDone),
    .done(done), .error(error), .result(result)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced on every rising edge
  int mPh = 0, mCnt = 0;
  bit mId, mCmp, mDir, mReqDir, mDone, mErr;
  int mRes = 0;

  always @(posedge clk) begin
    mDone = 1'b0;
    if (!rstN) begin
      mPh = 0; mCnt = 0; mRes = 0; mErr = 0; mDir = 0;
    end else begin
      case (mPh)
        0: if (start) begin mReqDir = reqDir; mRes = 0; mErr = 0; mPh = 1; end
        1, 3, 5: begin mPh = mPh + 1; mCnt = 0; end
        default: begin
          if (slotDone) begin
            if (mPh == 2) begin mId = slotRxBit; mPh = 3; end
            else if (mPh == 4) begin
              mCmp = slotRxBit;
              if (mId && mCmp) begin mRes = 3; mDone = 1; mPh = 0; end
              else begin mDir = (mId != mCmp) ? mId : mReqDir; mPh = 5; end
            end else begin
              mRes = {mDir, mCmp, mId}; mDone = 1; mPh = 0;
            end
          end else if (mCnt == LIM - 1) begin
            mRes = 3; mErr = 1; mDone = 1; mPh = 0;
          end else mCnt++;
        end
      endcase
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      bit expReq;
      expReq = (mPh == 1) || (mPh == 3) || (mPh == 5);
      check("R1 slotReq", slotReq, expReq);
      if (expReq) check("R1 slotIsRead", slotIsRead, mPh != 5);
      if (mPh == 5) check("R3 slotTxBit", slotTxBit, mDir);
      check("R8 done", done, mDone);
      check("R8 result", result, mRes);
      check("R6 error", error, mErr);
      if (countOn && slotReq) stepReqs++;
    end
  end

  task automatic serve(input bit rx, input int lat, input bit poke);
    for (int i = 0; i < 20; i++) begin
      if (slotReq) break;
      @(negedge clk);
    end
    if (lat == 0) return;
    for (int k = 1; k <= lat; k++) begin
      @(negedge clk);
      if (poke && k == 1) begin start = 1'b1; reqDir = ~reqDir; end
      else start = 1'b0;
    end
    slotDone = 1'b1; slotRxBit = rx;
    @(negedge clk);
    slotDone = 1'b0; slotRxBit = 1'b0; start = 1'b0;
  endtask

  task automatic doStep(input string tag, input bit dir, input bit id, input bit cmp,
                        input int latId, input int latCmp, input int latWr,
                        input bit poke, input int expRes, input bit expErr, input int expReqs);
    bit seen;
    int held;
    @(negedge clk);
    start = 1'b1; reqDir = dir;
    stepReqs = 0; countOn = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({tag, " R8 cleared result"}, result, 0);
    check({tag, " R8 cleared error"}, error, 0);
    serve(id, latId, poke);
    if (latId != 0) begin
      serve(cmp, latCmp, 1'b0);
      if (latCmp != 0 && !(id && cmp)) serve(1'b0, latWr, 1'b0);
    end
    seen = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (done) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    check({tag, " done seen"}, seen, 1);
    check({tag, " result"}, result, expRes);
    check({tag, " error"}, error, expErr);
    held = result;
    @(negedge clk);
    countOn = 1'b0;
    check({tag, " slot count"}, stepReqs, expReqs);
    check({tag, " R8 done falls"}, done, 0);
    check({tag, " R8 result held"}, result, held);
    repeat (2) @(negedge clk);
    check({tag, " R8 still held"}, result, held);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset slotReq", slotReq, 0);
    check("R9 reset done", done, 0);
    check("R9 reset error", error, 0);
    check("R9 reset result", result, 0);
    rstN = 1'b1;
    @(negedge clk);
    // tag  dir id cmp latId latCmp latWr poke res err reqs
    doStep("R3 conflict dir1", 1, 0, 0, 2, 3, 1, 0, 4, 0, 3);
    doStep("R3 conflict dir0", 0, 0, 0, 1, 1, 2, 0, 0, 0, 3);
    doStep("R4 id only",       0, 1, 0, 3, 1, 1, 0, 5, 0, 3);
    doStep("R4 cmp only",      1, 0, 1, 1, 2, 4, 0, 2, 0, 3);
    doStep("R2 no slave",      1, 1, 1, 2, 2, 0, 0, 3, 0, 2);
    doStep("R5 late id",       0, 1, 0, LIM, 1, LIM, 0, 5, 0, 3);
    doStep("R6 id timeout",    1, 0, 0, 0, 0, 0, 0, 3, 1, 1);
    doStep("R6 write timeout", 1, 0, 0, 1, 1, 0, 0, 3, 1, 3);
    doStep("R7 busy start",    1, 0, 0, 3, 1, 1, 1, 4, 0, 3);
    doStep("R5 after abort",   0, 0, 1, 1, LIM, 2, 0, 2, 0, 3);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule